// File: doc/BRIEF.md
# Synchronous PWM Shadow Update Controller

This block decides when buffered settings reach the live registers of a group of PWM channels that share one period counter. Each channel has a shadow and an active copy of its period, its duty cycle and its dead time. Software, or a DMA engine, writes the shadows through a simple write port. The active copies change only on a period-boundary strobe from the shared counter, so every channel of the group switches in the same PWM period.

A 2-bit mode input picks the update scheme:

- **Mode 0 (manual write, manual trigger):** one self-clearing unlock bit releases period, dead time and duty together.
- **Mode 1 (manual write, automatic trigger):** duty values are applied automatically every N+1 boundaries. The interval N is double-buffered and is reloaded at each automatic update.
- **Mode 2 (DMA write, automatic trigger):** duty values are applied the same way, and after each automatic update the block asks an external DMA engine to refill the duty shadows. That request can wait for a comparison-unit match.

In every mode the period and dead-time values follow the unlock bit. A one-clock pulse and a sticky flag mark each automatic duty update.

Top module: `pwm_sync_update_ctrl`

## Requirements
- R1: After reset, every active value, the active update interval, the unlock bit, the DMA request, the update pulse and the sticky flag are 0.
- R2: Writing a shadow never changes an active value by itself. A period boundary that arrives while the unlock bit is 0 leaves the active period and dead-time values unchanged.
- R3: A write with address 0 and data bit 0 equal to 1 sets the unlock bit; a write with bit 0 equal to 0 has no effect. The bit stays 1 until the first boundary seen while it is 1. At that boundary it clears, and the period and dead-time shadows of all channels become active in the next cycle. This holds in every mode.
- R4: In mode 0, and in mode 3, which behaves the same way, the duty shadows of all channels move to active at that same unlocked boundary.
- R5: In modes 1 and 2, a counter counts boundaries. The duty shadows move to active at the boundary where the counter equals the active interval N, and the counter then restarts at 0, so updates occur every N+1 boundaries. The unlock bit has no effect on duty values in these modes.
- R6: A write to address 1 loads the interval shadow. The shadow is copied to the active interval only at an automatic update in mode 1; in modes 0 and 2 it never reaches the active value.
- R7: Any change of the mode input clears the boundary counter.
- R8: In mode 2, the DMA request rises one clock after each automatic update, provided the match gate is off. It stays high until an acknowledge pulse, which drops it in the next cycle. Only one request is outstanding at a time: an update that occurs while a request is open raises a new request one clock after that request is acknowledged.
- R9: When the match gate input is 1, a due DMA request is held back until the comparison-match input is 1, and rises in the cycle after that.
- R10: Each automatic duty update raises the update pulse for one clock, in the cycle the new duty values appear, and sets the sticky flag. A status-read strobe clears the sticky flag, but a set in the same cycle wins over the clear.
- R11: When an unlock write and a boundary arrive in the same cycle, the boundary uses the previous unlock state. If that state was 0, nothing transfers and the unlock bit becomes 1 for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_mode | input | 2 | Update scheme select (0..3) |
| prd_edge | input | 1 | Period-boundary strobe from the shared counter |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address: 0 unlock, 1 interval shadow, 4+4c+{0,1,2} period/duty/dead time of channel c |
| wr_data | input | DATA_W | Write data |
| req_on_match | input | 1 | Hold DMA requests until a comparison match |
| cmp_match | input | 1 | Comparison-unit match strobe |
| dma_ack | input | 1 | DMA acknowledge pulse |
| stat_rd | input | 1 | Status read strobe; clears the sticky flag |
| prd_act | output | NUM_CH*PRD_W | Active periods, channel 0 in the low bits |
| dty_act | output | NUM_CH*DTY_W | Active duty cycles |
| dt_act | output | NUM_CH*DT_W | Active dead times |
| upr_act | output | UPR_W | Active automatic update interval |
| unlock_o | output | 1 | Unlock bit readback |
| dma_req | output | 1 | Duty refill request to the DMA engine |
| upd_pulse | output | 1 | One-clock automatic update marker |
| upd_sticky | output | 1 | Sticky automatic update flag |

## Verification
The bench builds the block with three channels, 12-bit periods, 10-bit duty values, 6-bit dead times, a 3-bit interval and a 5-bit address. The address map still fits after the elaboration checks, and each channel's fields land at distinct bit offsets of the flattened outputs. Using three channels shows that the transfers reach every channel in the same cycle, not only channel 0. The narrow interval field, programmed to 2, makes the every-third-boundary cadence, the counter clear on a mode change and the queued second DMA request reachable within a few dozen cycles.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

   typedef enum logic [1:0] {
      UPD_MANUAL     = 2'd0,
      UPD_AUTO_CPU   = 2'd1,
      UPD_AUTO_DMA   = 2'd2,
      UPD_MANUAL_ALT = 2'd3
   } upd_mode_e;

   localparam int unsigned REG_UNLOCK = 0;
   localparam int unsigned REG_UPR    = 1;
   localparam int unsigned CH_BASE    = 4;
   localparam int unsigned CH_STRIDE  = 4;
   localparam int unsigned OFS_PRD    = 0;
   localparam int unsigned OFS_DTY    = 1;
   localparam int unsigned OFS_DT     = 2;

   function automatic logic mode_is_auto(upd_mode_e m);
      return (m == UPD_AUTO_CPU) || (m == UPD_AUTO_DMA);
   endfunction

endpackage

// File: rtl/pwm_shadow_slot.sv
module pwm_shadow_slot #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   input  logic         xfer,
   output logic [W-1:0] act_o
);

   logic [W-1:0] shd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_q <= '0;
         act_o <= '0;
      end else begin
         if (ld)   shd_q <= d;
         // the active copy takes the shadow held before any same-cycle load
         if (xfer) act_o <= shd_q;
      end
   end

endmodule

// File: rtl/pwm_upd_sched.sv
module pwm_upd_sched
   import pwm_sync_pkg::*;
#(
   parameter int unsigned UPR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  upd_mode_e        mode,
   input  logic             prd_edge,
   input  logic             unl_set,
   input  logic             upr_ld,
   input  logic [UPR_W-1:0] upr_d,
   output logic             xfer_cfg,
   output logic             xfer_duty,
   output logic             auto_fire,
   output logic             unlock_o,
   output logic [UPR_W-1:0] upr_act
);

   upd_mode_e        mode_q;
   logic [UPR_W-1:0] cnt_q;
   logic [UPR_W-1:0] upr_shd_q;
   logic             mode_chg;
   logic             auto_on;
   logic             unl_fire;

   assign mode_chg  = (mode != mode_q);
   assign auto_on   = mode_is_auto(mode) && !mode_chg;
   assign unl_fire  = prd_edge && unlock_o;
   assign auto_fire = auto_on && prd_edge && (cnt_q == upr_act);
   assign xfer_cfg  = unl_fire;
   assign xfer_duty = mode_is_auto(mode) ? auto_fire : unl_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= UPD_MANUAL;
         unlock_o  <= 1'b0;
         cnt_q     <= '0;
         upr_shd_q <= '0;
         upr_act   <= '0;
      end else begin
         mode_q <= mode;
         // a fresh unlock write takes priority over the clear
         if (unl_set)       unlock_o <= 1'b1;
         else if (unl_fire) unlock_o <= 1'b0;
         if (mode_chg || !mode_is_auto(mode)) cnt_q <= '0;
         else if (prd_edge)                   cnt_q <= auto_fire ? '0 : cnt_q + 1'b1;
         if (upr_ld) upr_shd_q <= upr_d;
         if (auto_fire && (mode == UPD_AUTO_CPU)) upr_act <= upr_shd_q;
      end
   end

endmodule

// File: rtl/pwm_upd_flag.sv
module pwm_upd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic rd,
   output logic pulse_o,
   output logic sticky_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_o  <= 1'b0;
         sticky_o <= 1'b0;
      end else begin
         pulse_o <= fire;
         if (fire)    sticky_o <= 1'b1;
         else if (rd) sticky_o <= 1'b0;
      end
   end

endmodule

// File: rtl/pwm_dma_req_gen.sv
module pwm_dma_req_gen #(
   parameter bit MATCH_GATE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic match_en,
   input  logic match,
   input  logic ack,
   output logic req_o
);

   logic pend_q;
   logic gate_ok;
   logic issue;

   if (MATCH_GATE_EN) begin : g_gate
      assign gate_ok = !match_en || match;
   end else begin : g_nogate
      logic unused_gate;
      assign unused_gate = match_en ^ match;
      assign gate_ok     = 1'b1;
   end

   assign issue = pend_q && !req_o && gate_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         req_o  <= 1'b0;
      end else begin
         if (fire)       pend_q <= 1'b1;
         else if (issue) pend_q <= 1'b0;
         if (ack)        req_o <= 1'b0;
         else if (issue) req_o <= 1'b1;
      end
   end

endmodule

// File: rtl/pwm_sync_update_ctrl.sv
module pwm_sync_update_ctrl
   import pwm_sync_pkg::*;
#(
   parameter int unsigned NUM_CH        = 4,
   parameter int unsigned PRD_W         = 16,
   parameter int unsigned DTY_W         = 16,
   parameter int unsigned DT_W          = 8,
   parameter int unsigned UPR_W         = 4,
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned DATA_W        = 32,
   parameter bit          MATCH_GATE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              upd_mode,
   input  logic                    prd_edge,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    req_on_match,
   input  logic                    cmp_match,
   input  logic                    dma_ack,
   input  logic                    stat_rd,
   output logic [NUM_CH*PRD_W-1:0] prd_act,
   output logic [NUM_CH*DTY_W-1:0] dty_act,
   output logic [NUM_CH*DT_W-1:0]  dt_act,
   output logic [UPR_W-1:0]        upr_act,
   output logic                    unlock_o,
   output logic                    dma_req,
   output logic                    upd_pulse,
   output logic                    upd_sticky
);

   localparam int unsigned MAP_END = CH_BASE + NUM_CH * CH_STRIDE;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (PRD_W > DATA_W || DTY_W > DATA_W || DT_W > DATA_W || UPR_W > DATA_W) begin : g_bad_w
      $error("field wider than write data");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_map
      $error("address map exceeds ADDR_W");
   end

   upd_mode_e mode;
   logic      unl_set;
   logic      upr_ld;
   logic      xfer_cfg;
   logic      xfer_duty;
   logic      auto_fire;
   logic      unused_wdata;

   assign mode         = upd_mode_e'(upd_mode);
   assign unl_set      = wr_en && (wr_addr == ADDR_W'(REG_UNLOCK)) && wr_data[0];
   assign upr_ld       = wr_en && (wr_addr == ADDR_W'(REG_UPR));
   assign unused_wdata = ^wr_data;

   pwm_upd_sched #(.UPR_W(UPR_W)) i_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .prd_edge  (prd_edge),
      .unl_set   (unl_set),
      .upr_ld    (upr_ld),
      .upr_d     (wr_data[UPR_W-1:0]),
      .xfer_cfg  (xfer_cfg),
      .xfer_duty (xfer_duty),
      .auto_fire (auto_fire),
      .unlock_o  (unlock_o),
      .upr_act   (upr_act)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned BASE = CH_BASE + c * CH_STRIDE;

      pwm_shadow_slot #(.W(PRD_W)) i_prd (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (wr_en && (wr_addr == ADDR_W'(BASE + OFS_PRD))),
         .d     (wr_data[PRD_W-1:0]),
         .xfer  (xfer_cfg),
         .act_o (prd_act[c*PRD_W +: PRD_W])
      );

      pwm_shadow_slot #(.W(DTY_W)) i_dty (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (wr_en && (wr_addr == ADDR_W'(BASE + OFS_DTY))),
         .d     (wr_data[DTY_W-1:0]),
         .xfer  (xfer_duty),
         .act_o (dty_act[c*DTY_W +: DTY_W])
      );

      pwm_shadow_slot #(.W(DT_W)) i_dt (
         .clk   (clk),
         .rst_n (rst_n),
         .ld    (wr_en && (wr_addr == ADDR_W'(BASE + OFS_DT))),
         .d     (wr_data[DT_W-1:0]),
         .xfer  (xfer_cfg),
         .act_o (dt_act[c*DT_W +: DT_W])
      );
   end

   pwm_upd_flag i_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (auto_fire),
      .rd       (stat_rd),
      .pulse_o  (upd_pulse),
      .sticky_o (upd_sticky)
   );

   pwm_dma_req_gen #(.MATCH_GATE_EN(MATCH_GATE_EN)) i_dma (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (auto_fire && (mode == UPD_AUTO_DMA)),
      .match_en (req_on_match),
      .match    (cmp_match),
      .ack      (dma_ack),
      .req_o    (dma_req)
   );

endmodule

// File: rtl/pwm_sync_update_chk.sv
module pwm_sync_update_chk #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned PRD_W  = 16,
   parameter int unsigned DTY_W  = 16,
   parameter int unsigned DT_W   = 8,
   parameter int unsigned UPR_W  = 4,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              upd_mode,
   input logic                    prd_edge,
   input logic                    wr_en,
   input logic [ADDR_W-1:0]       wr_addr,
   input logic [DATA_W-1:0]       wr_data,
   input logic                    dma_ack,
   input logic [NUM_CH*PRD_W-1:0] prd_act,
   input logic [NUM_CH*DTY_W-1:0] dty_act,
   input logic [NUM_CH*DT_W-1:0]  dt_act,
   input logic [UPR_W-1:0]        upr_act,
   input logic                    unlock_o,
   input logic                    dma_req,
   input logic                    upd_pulse,
   input logic                    upd_sticky
);

   logic unl_wr;
   assign unl_wr = wr_en && (wr_addr == '0) && wr_data[0];

   assert_no_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !prd_edge |=> $stable(prd_act) && $stable(dty_act) && $stable(dt_act) && $stable(upr_act));

   assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !unlock_o |=> $stable(prd_act) && $stable(dt_act));

   assert_unlock_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_o && prd_edge && !unl_wr |=> !unlock_o);

   assert_unlock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_o && !prd_edge |=> unlock_o);

   assert_auto_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> $past(upd_mode == 2'd1 || upd_mode == 2'd2));

   assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_ack |=> dma_req);

   assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ack |=> !dma_req);

   assert_pulse_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> $past(prd_edge));

   assert_pulse_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pulse |-> upd_sticky);

endmodule

bind pwm_sync_update_ctrl pwm_sync_update_chk #(
   .NUM_CH (NUM_CH),
   .PRD_W  (PRD_W),
   .DTY_W  (DTY_W),
   .DT_W   (DT_W),
   .UPR_W  (UPR_W),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_mode   (upd_mode),
   .prd_edge   (prd_edge),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .dma_ack    (dma_ack),
   .prd_act    (prd_act),
   .dty_act    (dty_act),
   .dt_act     (dt_act),
   .upr_act    (upr_act),
   .unlock_o   (unlock_o),
   .dma_req    (dma_req),
   .upd_pulse  (upd_pulse),
   .upd_sticky (upd_sticky)
);

// File: tb/test_pwm_sync_update_ctrl.sv
module test_pwm_sync_update_ctrl;

   localparam int NCH = 3;
   localparam int PW  = 12;
   localparam int DW  = 10;
   localparam int TW  = 6;
   localparam int UW  = 3;
   localparam int AW  = 5;
   localparam int XW  = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      upd_mode = '0;
   logic            prd_edge = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [XW-1:0]   wr_data = '0;
   logic            req_on_match = 1'b0;
   logic            cmp_match = 1'b0;
   logic            dma_ack = 1'b0;
   logic            stat_rd = 1'b0;
   logic [NCH*PW-1:0] prd_act;
   logic [NCH*DW-1:0] dty_act;
   logic [NCH*TW-1:0] dt_act;
   logic [UW-1:0]   upr_act;
   logic            unlock_o, dma_req, upd_pulse, upd_sticky;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pwm_sync_update_ctrl #(
      .NUM_CH(NCH), .PRD_W(PW), .DTY_W(DW), .DT_W(TW),
      .UPR_W(UW), .ADDR_W(AW), .DATA_W(XW), .MATCH_GATE_EN(1'b1)
   ) i_pwm_sync_update_ctrl (
      .clk(clk), .rst_n(rst_n), .upd_mode(upd_mode), .prd_edge(prd_edge),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .req_on_match(req_on_match), .cmp_match(cmp_match), .dma_ack(dma_ack),
      .stat_rd(stat_rd), .prd_act(prd_act), .dty_act(dty_act), .dt_act(dt_act),
      .upr_act(upr_act), .unlock_o(unlock_o), .dma_req(dma_req),
      .upd_pulse(upd_pulse), .upd_sticky(upd_sticky)
   );

   function automatic int prd_of(int c); return int'(prd_act[c*PW +: PW]); endfunction
   function automatic int dty_of(int c); return int'(dty_act[c*DW +: DW]); endfunction
   function automatic int dt_of(int c);  return int'(dt_act[c*TW +: TW]);  endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = XW'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic edge1();
      prd_edge = 1'b1;
      tick();
      prd_edge = 1'b0;
   endtask

   function automatic int ch_addr(int c, int ofs); return 4 + 4*c + ofs; endfunction

   task automatic t_reset();
      for (int c = 0; c < NCH; c++) begin
         chk("R1 prd", prd_of(c), 0);
         chk("R1 dty", dty_of(c), 0);
         chk("R1 dt", dt_of(c), 0);
      end
      chk("R1 upr", int'(upr_act), 0);
      chk("R1 unlock", int'(unlock_o), 0);
      chk("R1 req", int'(dma_req), 0);
      chk("R1 pulse", int'(upd_pulse), 0);
      chk("R1 sticky", int'(upd_sticky), 0);
   endtask

   task automatic t_manual();
      upd_mode = 2'd0;
      for (int c = 0; c < NCH; c++) begin
         wr(ch_addr(c, 0), 100 + c);
         wr(ch_addr(c, 1), 50 + c);
         wr(ch_addr(c, 2), 5 + c);
      end
      edge1();
      for (int c = 0; c < NCH; c++) begin
         chk("R2 locked prd", prd_of(c), 0);
         chk("R2 locked dt", dt_of(c), 0);
         chk("R4 locked dty", dty_of(c), 0);
      end
      wr(0, 0);
      chk("R3 write0 ignored", int'(unlock_o), 0);
      wr(0, 1);
      chk("R3 unlock set", int'(unlock_o), 1);
      tick(); tick(); tick();
      chk("R3 unlock held", int'(unlock_o), 1);
      chk("R2 no edge", prd_of(0), 0);
      edge1();
      for (int c = 0; c < NCH; c++) begin
         chk("R3 prd xfer", prd_of(c), 100 + c);
         chk("R3 dt xfer", dt_of(c), 5 + c);
         chk("R4 dty xfer", dty_of(c), 50 + c);
      end
      chk("R3 unlock clears", int'(unlock_o), 0);
      wr(ch_addr(0, 0), 200);
      edge1();
      chk("R2 relocked", prd_of(0), 100);
   endtask

   task automatic t_same_cycle();
      prd_edge = 1'b1; wr_en = 1'b1; wr_addr = '0; wr_data = 1;
      tick();
      prd_edge = 1'b0; wr_en = 1'b0;
      chk("R11 old state used", prd_of(0), 100);
      chk("R11 unlock set", int'(unlock_o), 1);
      edge1();
      chk("R11 next edge xfer", prd_of(0), 200);
   endtask

   task automatic t_mode3();
      upd_mode = 2'd3;
      tick();
      wr(ch_addr(1, 1), 77);
      wr(0, 1);
      edge1();
      chk("R4 mode3 duty", dty_of(1), 77);
      chk("R10 no pulse manual", int'(upd_pulse), 0);
   endtask

   task automatic t_auto();
      upd_mode = 2'd1;
      tick();
      wr(1, 2);
      for (int c = 0; c < NCH; c++) wr(ch_addr(c, 1), 60 + c);
      edge1();
      for (int c = 0; c < NCH; c++) chk("R5 first auto", dty_of(c), 60 + c);
      chk("R6 upr loaded", int'(upr_act), 2);
      chk("R10 pulse", int'(upd_pulse), 1);
      chk("R10 sticky", int'(upd_sticky), 1);
      tick();
      chk("R10 pulse one clock", int'(upd_pulse), 0);
      stat_rd = 1'b1; tick(); stat_rd = 1'b0;
      chk("R10 read clears", int'(upd_sticky), 0);
      for (int c = 0; c < NCH; c++) wr(ch_addr(c, 1), 70 + c);
      wr(ch_addr(2, 0), 300);
      wr(0, 1);
      edge1();
      chk("R3 cfg in mode1", prd_of(2), 300);
      chk("R5 unlock no duty", dty_of(0), 60);
      edge1();
      chk("R5 second edge", dty_of(0), 60);
      prd_edge = 1'b1; stat_rd = 1'b1;
      tick();
      prd_edge = 1'b0; stat_rd = 1'b0;
      for (int c = 0; c < NCH; c++) chk("R5 third edge", dty_of(c), 70 + c);
      chk("R10 set wins", int'(upd_sticky), 1);
   endtask

   task automatic t_mode_change();
      edge1();
      wr(ch_addr(0, 1), 90);
      upd_mode = 2'd0; tick();
      upd_mode = 2'd1; tick();
      edge1();
      edge1();
      chk("R7 counter cleared", dty_of(0), 70);
      edge1();
      chk("R7 fires after restart", dty_of(0), 90);
   endtask

   task automatic t_dma();
      upd_mode = 2'd2;
      tick();
      wr(1, 0);
      wr(ch_addr(1, 1), 33);
      edge1(); edge1();
      chk("R5 mode2 wait", dty_of(1), 71);
      edge1();
      chk("R5 mode2 fire", dty_of(1), 33);
      chk("R6 shadow ignored mode2", int'(upr_act), 2);
      chk("R8 req not yet", int'(dma_req), 0);
      tick();
      chk("R8 req raised", int'(dma_req), 1);
      tick(); tick(); tick();
      chk("R8 req held", int'(dma_req), 1);
      edge1(); edge1(); edge1();
      chk("R8 still one req", int'(dma_req), 1);
      dma_ack = 1'b1; tick(); dma_ack = 1'b0;
      chk("R8 ack drops", int'(dma_req), 0);
      tick();
      chk("R8 queued req", int'(dma_req), 1);
      dma_ack = 1'b1; tick(); dma_ack = 1'b0;
      tick(); tick();
      chk("R8 none left", int'(dma_req), 0);
   endtask

   task automatic t_match();
      req_on_match = 1'b1;
      edge1(); edge1(); edge1();
      tick(); tick();
      chk("R9 waits match", int'(dma_req), 0);
      cmp_match = 1'b1; tick(); cmp_match = 1'b0;
      chk("R9 match releases", int'(dma_req), 1);
      dma_ack = 1'b1; tick(); dma_ack = 1'b0;
      chk("R9 acked", int'(dma_req), 0);
      req_on_match = 1'b0;
   endtask

   initial begin
      tick(); tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_manual();
      t_same_cycle();
      t_mode3();
      t_auto();
      t_mode_change();
      t_dma();
      t_match();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule